// File: doc/BRIEF.md
# Vertical Sync Windowed Divider

This block sits between a sync separator and a vertical ramp generator. It counts half-line ticks since the last vertical retrace. From that count and from the detected vertical sync, it decides when the next retrace starts. When the input is weak or missing, it stays calm. When the input is a clean broadcast signal, it locks onto the exact field length.

The block has three modes:
- **Search:** a wide acceptance window is used.
- **Narrow:** a tight window is centred on the expected field length, and the block fly-wheels through a missing sync.
- **Locked:** retrace fires at exactly the standard field length whether or not a sync arrives.

Mode changes follow counts of consecutive hits and misses. A control bit can force the block back to search at once, for example during a tuner channel change.

Counting is done in half-lines, so an interlaced field of 312.5 or 262.5 lines is represented exactly, as 625 or 525 counts. The same counts set the expected field length for the 50 Hz and 60 Hz rates. The rate can be forced either way, or classified automatically from the measured length of sync-triggered fields.

Top module: `vsync_divider`

## Requirements
- R1: `field_len` holds the number of half-line ticks from the previous retrace up to and including the tick that triggered the current one. `retrace` is a one-cycle pulse in the clock cycle after that tick, and `field_len` changes in the same cycle.
- R2: `vsync` is taken into account only in a cycle where `hl_tick` is high. A sync in any other cycle is ignored.
- R3: In search mode, a sync at count 488 to 722 starts a retrace. A sync at any other count is ignored. With no accepted sync, a free-running retrace fires at count 722.
- R4: The block moves from search to narrow mode on the 16th consecutive search retrace caused by a sync that lies within expected ±6 counts. Expected is 625 at 50 Hz and 525 at 60 Hz. Any other search retrace clears the run.
- R5: In narrow mode, a sync within expected ±6 starts retrace and a sync outside that window is ignored. Without an accepted sync, a fly-wheel retrace fires at expected+6.
- R6: The block moves from narrow to locked mode on the 15th consecutive narrow retrace caused by a sync at exactly the expected count. Any other narrow retrace clears the run.
- R7: In locked mode, every retrace fires at exactly the expected count, and syncs at any other count are ignored. Three consecutive locked fields without a sync at the expected count return the block to narrow mode.
- R8: Six consecutive fly-wheel retraces in narrow mode return the block to search mode. The limit is three when narrow mode was entered from locked mode.
- R9: A high `force_search` sets search mode on the next clock and clears all hit and miss runs.
- R10: `rate_sel` selects the rate:
  - 2'b01 forces 50 Hz.
  - 2'b10 forces 60 Hz.
  - Any other value selects the automatic rate. The automatic rate becomes 50 Hz after a sync-triggered retrace whose length is at least 575, and 60 Hz after one that is shorter.

  `rate_50` is high for 50 Hz and changes in the same cycle as the selection or classification that causes it.
- R11: After reset, `mode` is 0 and `retrace` is 0. `field_len` is 0, and `rate_50` is 1 because the automatic rate starts at 50 Hz. The mode codes are 0 for search, 1 for narrow and 2 for locked; code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hl_tick | input | 1 | One-cycle strobe per half line |
| vsync | input | 1 | Detected vertical sync, aligned to a tick |
| rate_sel | input | 2 | Rate control: 01 = 50 Hz, 10 = 60 Hz, other = automatic |
| force_search | input | 1 | Force search mode and clear the runs |
| retrace | output | 1 | Vertical retrace start pulse |
| mode | output | 2 | Current mode: 0 = search, 1 = narrow, 2 = locked |
| field_len | output | 11 | Half-line count of the last field |
| rate_50 | output | 1 | Active rate is 50 Hz |

## Verification
The hardest state to reach from the ports is narrow mode entered from locked mode. Reaching it takes 16 accepted search fields, then 15 exact-norm narrow fields, then three missing syncs in locked mode. Only after that does the shorter miss limit apply. The stimulus is a table of field descriptions that the bench replays one field at a time through this whole path. A second pass at 525 counts then drives the automatic classification and the window move from 50 Hz to 60 Hz.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;

  typedef enum logic [1:0] {
    VM_SEARCH = 2'd0,
    VM_NARROW = 2'd1,
    VM_LOCKED = 2'd2
  } vmode_e;

  typedef struct packed {
    logic in_search;
    logic in_narrow;
    logic at_norm;
    logic at_search_end;
    logic at_narrow_end;
  } vwin_s;

endpackage

// File: rtl/vdiv_line_ctr.sv
module vdiv_line_ctr #(
  parameter int HL_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            restart,
  output logic [HL_W-1:0] pos
);

  localparam logic [HL_W-1:0] CNT_MAX = {HL_W{1'b1}};

  logic [HL_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (restart) begin
        cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // position of the half line being ticked right now
  always_comb pos = cnt_q + 1'b1;

endmodule

// File: rtl/vdiv_window.sv
module vdiv_window
  import vdiv_pkg::*;
#(
  parameter int HL_W    = 11,
  parameter int SW_LO   = 488,
  parameter int SW_HI   = 722,
  parameter int NW_HALF = 6
) (
  input  logic [HL_W-1:0] pos,
  input  logic [HL_W-1:0] expect_len,
  output vwin_s           win
);

  localparam logic [HL_W-1:0] LO_S = HL_W'(SW_LO);
  localparam logic [HL_W-1:0] HI_S = HL_W'(SW_HI);
  localparam logic [HL_W-1:0] HALF = HL_W'(NW_HALF);

  logic [HL_W-1:0] nw_lo;
  logic [HL_W-1:0] nw_hi;

  always_comb begin
    nw_lo             = expect_len - HALF;
    nw_hi             = expect_len + HALF;
    win.in_search     = (pos >= LO_S) && (pos <= HI_S);
    win.in_narrow     = (pos >= nw_lo) && (pos <= nw_hi);
    win.at_norm       = (pos == expect_len);
    win.at_search_end = (pos == HI_S);
    win.at_narrow_end = (pos == nw_hi);
  end

endmodule

// File: rtl/vdiv_rate.sv
module vdiv_rate #(
  parameter int HL_W       = 11,
  parameter int RATE_SPLIT = 575
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      rate_sel,
  input  logic            sync_retrace,
  input  logic [HL_W-1:0] len,
  output logic            is50
);

  logic auto50_q;
  logic auto50_d;

  always_comb begin
    auto50_d = auto50_q;
    if (sync_retrace) auto50_d = (len >= HL_W'(RATE_SPLIT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto50_q <= 1'b1;
      is50     <= 1'b1;
    end else begin
      auto50_q <= auto50_d;
      case (rate_sel)
        2'b01:   is50 <= 1'b1;
        2'b10:   is50 <= 1'b0;
        default: is50 <= auto50_d;
      endcase
    end
  end

endmodule

// File: rtl/vdiv_mode_fsm.sv
module vdiv_mode_fsm
  import vdiv_pkg::*;
#(
  parameter int NW_HITS     = 16,
  parameter int NORM_HITS   = 15,
  parameter int NARROW_MISS = 6,
  parameter int LOCK_MISS   = 3,
  parameter int REENTRY_MISS = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   vsync,
  input  logic   force_search,
  input  vwin_s  win,
  output vmode_e mode,
  output logic   fire,
  output logic   take
);

  localparam int MAXH   = (NW_HITS > NORM_HITS) ? NW_HITS : NORM_HITS;
  localparam int HIT_W  = $clog2(MAXH + 1);
  localparam int MAXM1  = (NARROW_MISS > LOCK_MISS) ? NARROW_MISS : LOCK_MISS;
  localparam int MAXM   = (MAXM1 > REENTRY_MISS) ? MAXM1 : REENTRY_MISS;
  localparam int MISS_W = $clog2(MAXM + 1);

  logic [HIT_W-1:0]  hits_q;
  logic [MISS_W-1:0] miss_q;
  logic              from_lock_q;
  logic              sync;
  logic [MISS_W-1:0] narrow_lim;

  always_comb begin
    sync = tick & vsync;
    take = 1'b0;
    fire = 1'b0;
    case (mode)
      VM_SEARCH: begin
        take = sync & win.in_search;
        fire = take | (tick & win.at_search_end);
      end
      VM_NARROW: begin
        take = sync & win.in_narrow;
        fire = take | (tick & win.at_narrow_end);
      end
      default: begin
        take = sync & win.at_norm;
        fire = tick & win.at_norm;
      end
    endcase
    narrow_lim = from_lock_q ? MISS_W'(REENTRY_MISS - 1) : MISS_W'(NARROW_MISS - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || force_search) begin
      mode        <= VM_SEARCH;
      hits_q      <= '0;
      miss_q      <= '0;
      from_lock_q <= 1'b0;
    end else if (fire) begin
      case (mode)
        VM_SEARCH: begin
          if (take && win.in_narrow) begin
            if (hits_q == HIT_W'(NW_HITS - 1)) begin
              mode        <= VM_NARROW;
              hits_q      <= '0;
              miss_q      <= '0;
              from_lock_q <= 1'b0;
            end else begin
              hits_q <= hits_q + 1'b1;
            end
          end else begin
            hits_q <= '0;
          end
        end
        VM_NARROW: begin
          if (take) begin
            miss_q <= '0;
            if (win.at_norm) begin
              if (hits_q == HIT_W'(NORM_HITS - 1)) begin
                mode   <= VM_LOCKED;
                hits_q <= '0;
              end else begin
                hits_q <= hits_q + 1'b1;
              end
            end else begin
              hits_q <= '0;
            end
          end else begin
            hits_q <= '0;
            if (miss_q == narrow_lim) begin
              mode        <= VM_SEARCH;
              miss_q      <= '0;
              from_lock_q <= 1'b0;
            end else begin
              miss_q <= miss_q + 1'b1;
            end
          end
        end
        default: begin
          if (take) begin
            miss_q <= '0;
          end else if (miss_q == MISS_W'(LOCK_MISS - 1)) begin
            mode        <= VM_NARROW;
            miss_q      <= '0;
            hits_q      <= '0;
            from_lock_q <= 1'b1;
          end else begin
            miss_q <= miss_q + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/vsync_divider.sv
module vsync_divider
  import vdiv_pkg::*;
#(
  parameter int HL_W         = 11,
  parameter int SW_LO        = 488,
  parameter int SW_HI        = 722,
  parameter int NW_HALF      = 6,
  parameter int EXP_50       = 625,
  parameter int EXP_60       = 525,
  parameter int RATE_SPLIT   = 575,
  parameter int NW_HITS      = 16,
  parameter int NORM_HITS    = 15,
  parameter int NARROW_MISS  = 6,
  parameter int LOCK_MISS    = 3,
  parameter int REENTRY_MISS = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hl_tick,
  input  logic            vsync,
  input  logic [1:0]      rate_sel,
  input  logic            force_search,
  output logic            retrace,
  output logic [1:0]      mode,
  output logic [HL_W-1:0] field_len,
  output logic            rate_50
);

  logic [HL_W-1:0] pos;
  logic [HL_W-1:0] expect_len;
  vwin_s           win;
  vmode_e          mode_st;
  logic            fire;
  logic            take;

  always_comb expect_len = rate_50 ? HL_W'(EXP_50) : HL_W'(EXP_60);

  vdiv_line_ctr #(.HL_W(HL_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .tick    (hl_tick),
    .restart (fire),
    .pos     (pos)
  );

  vdiv_window #(
    .HL_W(HL_W), .SW_LO(SW_LO), .SW_HI(SW_HI), .NW_HALF(NW_HALF)
  ) u_win (
    .pos        (pos),
    .expect_len (expect_len),
    .win        (win)
  );

  vdiv_mode_fsm #(
    .NW_HITS(NW_HITS), .NORM_HITS(NORM_HITS), .NARROW_MISS(NARROW_MISS),
    .LOCK_MISS(LOCK_MISS), .REENTRY_MISS(REENTRY_MISS)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .tick         (hl_tick),
    .vsync        (vsync),
    .force_search (force_search),
    .win          (win),
    .mode         (mode_st),
    .fire         (fire),
    .take         (take)
  );

  vdiv_rate #(.HL_W(HL_W), .RATE_SPLIT(RATE_SPLIT)) u_rate (
    .clk          (clk),
    .rst          (rst),
    .rate_sel     (rate_sel),
    .sync_retrace (take),
    .len          (pos),
    .is50         (rate_50)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      retrace   <= 1'b0;
      field_len <= '0;
    end else begin
      retrace <= fire;
      if (fire) field_len <= pos;
    end
  end

  always_comb mode = mode_st;

endmodule

// File: rtl/vdiv_checker.sv
module vdiv_checker #(
  parameter int HL_W   = 11,
  parameter int SW_HI  = 722,
  parameter int EXP_50 = 625,
  parameter int EXP_60 = 525
) (
  input logic            clk,
  input logic            rst,
  input logic            hl_tick,
  input logic            force_search,
  input logic            retrace,
  input logic [1:0]      mode,
  input logic [HL_W-1:0] field_len
);

  AST_RETRACE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    retrace |=> !retrace); // R1

  AST_RETRACE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    retrace |-> $past(hl_tick)); // R2

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    retrace |-> (field_len <= HL_W'(SW_HI))); // R3

  AST_NO_SEARCH_TO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && !retrace) |=> (mode != 2'd2)); // R6

  AST_LOCKED_LEN: assert property (@(posedge clk) disable iff (rst)
    (retrace && mode == 2'd2 && $past(mode) == 2'd2)
      |-> (field_len == HL_W'(EXP_50) || field_len == HL_W'(EXP_60))); // R7

  AST_FORCE_SEARCH: assert property (@(posedge clk) disable iff (rst)
    force_search |=> (mode == 2'd0)); // R9

  AST_MODE_CODE: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3); // R11

endmodule

bind vsync_divider vdiv_checker #(
  .HL_W(HL_W), .SW_HI(SW_HI), .EXP_50(EXP_50), .EXP_60(EXP_60)
) u_vdiv_checker (
  .clk          (clk),
  .rst          (rst),
  .hl_tick      (hl_tick),
  .force_search (force_search),
  .retrace      (retrace),
  .mode         (mode),
  .field_len    (field_len)
);

// File: tb/vsync_divider_bench.sv
module vsync_divider_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hl_tick = 1'b0;
  logic        vsync = 1'b0;
  logic [1:0]  rate_sel = 2'b00;
  logic        force_search = 1'b0;
  logic        retrace;
  logic [1:0]  mode;
  logic [10:0] field_len;
  logic        rate_50;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  vsync_divider u_vsync_divider (
    .clk(clk), .rst(rst), .hl_tick(hl_tick), .vsync(vsync),
    .rate_sel(rate_sel), .force_search(force_search),
    .retrace(retrace), .mode(mode), .field_len(field_len), .rate_50(rate_50)
  );

  // columns: sync position (0 = none), field count, expected length,
  // expected mode during the run, expected mode after the last field
  localparam int NV = 15;
  localparam int VEC [NV][5] = '{
    '{100, 1,  722, 0, 0},
    '{700, 1,  700, 0, 0},
    '{625, 15, 625, 0, 0},
    '{625, 1,  625, 0, 1},
    '{623, 1,  623, 1, 1},
    '{625, 14, 625, 1, 1},
    '{625, 1,  625, 1, 2},
    '{0,   2,  625, 2, 2},
    '{625, 1,  625, 2, 2},
    '{0,   3,  625, 2, 1},
    '{0,   3,  631, 1, 0},
    '{0,   1,  722, 0, 0},
    '{625, 16, 625, 0, 1},
    '{500, 5,  631, 1, 1},
    '{500, 1,  631, 1, 0}
  };
  string vtag [NV];

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drives ticks every cycle until retrace is seen; returns the field length
  task automatic run_field(input int vs_at, input int gap_at, output int len);
    int p = 0;
    len = 0;
    while (len == 0 && p < 2000) begin
      if (p + 1 == gap_at) begin
        hl_tick = 1'b0;
        vsync   = 1'b1;
        @(negedge clk);
      end
      p++;
      hl_tick = 1'b1;
      vsync   = (p == vs_at);
      @(negedge clk);
      if (retrace) len = p;
    end
    hl_tick = 1'b0;
    vsync   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    int len;
    vtag = '{"R3", "R3", "R4", "R4", "R6", "R6", "R6", "R7",
             "R7", "R7", "R8", "R3", "R4", "R5", "R8"};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 mode", mode, 0);
    chk("R11 retrace", retrace, 0);
    chk("R11 field_len", field_len, 0);
    chk("R11 rate_50", rate_50, 1);

    for (int i = 0; i < NV; i++) begin
      for (int r = 0; r < VEC[i][1]; r++) begin
        run_field(VEC[i][0], 0, len);
        chk("R1 length", len, VEC[i][2]);
        chk("R1 field_len", field_len, VEC[i][2]);
        chk(vtag[i], mode, (r == VEC[i][1] - 1) ? VEC[i][4] : VEC[i][3]);
      end
    end

    // R2: sync in a cycle without a tick, inside the search window
    run_field(0, 600, len);
    chk("R2 untick sync ignored", len, 722);

    // R10: automatic classification to 60 Hz
    run_field(525, 0, len);
    chk("R10 len 525", len, 525);
    chk("R10 auto 60", rate_50, 0);
    for (int r = 0; r < 16; r++) begin
      run_field(525, 0, len);
      chk("R4 60Hz len", len, 525);
    end
    chk("R4 60Hz narrow", mode, 1);
    for (int r = 0; r < 15; r++) begin
      run_field(525, 0, len);
      chk("R6 60Hz len", len, 525);
    end
    chk("R6 60Hz locked", mode, 2);
    run_field(0, 0, len);
    chk("R7 60Hz flywheel", len, 525);

    // R10: forced rates
    rate_sel = 2'b01;
    @(negedge clk);
    chk("R10 forced 50", rate_50, 1);
    run_field(0, 0, len);
    chk("R7 locked at 625", len, 625);
    rate_sel = 2'b00;
    @(negedge clk);
    chk("R10 back to auto 60", rate_50, 0);
    rate_sel = 2'b10;
    @(negedge clk);
    chk("R10 forced 60", rate_50, 0);
    rate_sel = 2'b00;

    // R9: force search from locked
    chk("R9 pre mode", mode, 2);
    force_search = 1'b1;
    @(negedge clk);
    force_search = 1'b0;
    chk("R9 forced search", mode, 0);
    run_field(0, 0, len);
    chk("R9 search free run", len, 722);
    chk("R9 mode stays", mode, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule